// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Controller

This block holds the interrupt side of a PC-style real-time clock. Three single-cycle event pulses come in from the surrounding clock logic: a periodic tick, an alarm match and an update-ended strobe. Each pulse latches into its own flag. A control register holds one enable per event, together with three mode bits. A summary request flag collects the events that are enabled, and an active-low interrupt line follows that summary flag.

Software reads the flag register to learn which events occurred. That read also clears every flag and the summary bit. Each enable sits at the same bit position as its flag, so the flag byte can be masked with the control byte directly. The block does no timekeeping, alarm comparison or rate division; all of those arrive as pulses.

Top module: `rtc_irq_ctl`

## Requirements
- R1: After reset the control register reads 0x00, the flag register reads 0x00 and `irq_n` is high.
- R2: A write with `reg_sel`=0 stores periodic enable (bit 6), alarm enable (bit 5), update enable (bit 4), binary mode (bit 2), 24-hour mode (bit 1) and daylight-saving enable (bit 0). Bits 7 and 3 always read as 0.
- R3: A pulse on `ev_periodic`, `ev_alarm` or `ev_update` sets flag-register bit 6, 5 or 4 respectively on the next cycle. This happens whether or not the matching enable is set.
- R4: The summary bit (flag-register bit 7) becomes 1 in the cycle after the set flags and the set enables first share a bit. This includes the case where an enable is written after its flag was already set. Once set, the summary bit stays 1 until the flag register is read.
- R5: `irq_n` is low exactly while the summary bit is 1.
- R6: A read with `reg_sel`=1 and `rd_en`=1 returns the current flag byte on `rdata` in that cycle. From the next cycle on, all flags and the summary bit are 0.
- R7: An event pulse in the same cycle as a flag-register read is not lost. Its flag is 1 after the read. If that event is enabled, the summary bit is also 1 after the read.
- R8: Flag-register bits 3..0 always read as 0. A write with `reg_sel`=1 changes neither the flags nor the control register.
- R9: Writing the control register with the alarm enable cleared, then reading the flag register, leaves the summary bit at 0 and `irq_n` high, provided no new enabled event arrives.
- R10: Reading the control register does not change the flags or the summary bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_periodic | input | 1 | Periodic tick pulse |
| ev_alarm | input | 1 | Alarm match pulse |
| ev_update | input | 1 | Update-ended pulse |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the flag register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears the flags when the flag register is selected) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The main sweep covers every combination of the three enables against every combination of the three event pulses. It shows that raw flags follow the events alone, while the summary bit and `irq_n` follow only their intersection. A sweep over all 256 control-write values separates the stored bits from the bits that are tied to zero. Directed sequences cover four cases:
- an enable written after its flag is already set, which tells a level-driven summary from a pulse-driven one;
- an event that coincides with a flag read, which tells a survived flag from a lost one;
- the one-shot alarm disable followed by a flag read;
- reads of the control register and writes to the flag register, which must have no side effects.

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_periodic,
  input  logic       ev_alarm,
  input  logic       ev_update,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_n
);

  logic [2:0] en_q, en_d, flg_q, flg_d, ev, mode_q;
  logic       irqf_q, irqf_d, ctl_wr, flg_rd;

  assign ev     = {ev_periodic, ev_alarm, ev_update};
  assign ctl_wr = wr_en & ~reg_sel;
  assign flg_rd = rd_en & reg_sel;
  assign en_d   = ctl_wr ? wdata[6:4] : en_q;
  assign flg_d  = (flg_rd ? 3'b000 : flg_q) | ev;
  assign irqf_d = (irqf_q & ~flg_rd) | (|(flg_d & en_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      flg_q  <= '0;
      irqf_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      flg_q  <= flg_d;
      irqf_q <= irqf_d;
      if (ctl_wr) mode_q <= wdata[2:0];
    end
  end

  assign rdata = reg_sel ? {irqf_q, flg_q, 4'h0} : {1'b0, en_q, 1'b0, mode_q};
  assign irq_n = ~irqf_q;

  a_r3_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alarm |=> rdata[5] || !reg_sel);
  a_r4_irqf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irqf_q && !flg_rd) |=> irqf_q);
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> (|(flg_q & en_q)));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_rd && ev == 3'b000) |=> (flg_q == 3'b000 && irq_n));
  a_r7_coincide: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_rd && ev_periodic) |=> flg_q[2]);
  a_r8_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> rdata[3:0] == 4'h0);

endmodule

// File: tb/rtc_irq_ctl_test.sv
module rtc_irq_ctl_test;
  logic clk = 0, rst_n = 0;
  logic ev_periodic = 0, ev_alarm = 0, ev_update = 0;
  logic reg_sel = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq_n;
  int checks = 0, fails = 0;
  logic [7:0] d;

  always #2 clk = ~clk;

  rtc_irq_ctl uut (.clk(clk), .rst_n(rst_n), .ev_periodic(ev_periodic), .ev_alarm(ev_alarm),
    .ev_update(ev_update), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk); reg_sel = sel; wr_en = 1; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk); reg_sel = sel; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk); {ev_periodic, ev_alarm, ev_update} = m;
    @(negedge clk); {ev_periodic, ev_alarm, ev_update} = 3'b000;
  endtask

  task automatic peek_flags(output logic [7:0] v);
    @(negedge clk); reg_sel = 1; #1 v = rdata;
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    reg_sel = 0; #1 chk("R1 ctl", rdata, 8'h00);
    reg_sel = 1; #1 chk("R1 flags", rdata, 8'h00);
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);

    for (int w = 0; w < 256; w++) begin
      wr(0, w[7:0]);
      rd(0, d);
      chk("R2 ctl readback", d, w[7:0] & 8'h77);
    end

    for (int e = 0; e < 8; e++) begin
      for (int m = 0; m < 8; m++) begin
        logic x;
        wr(0, {1'b0, e[2:0], 4'h0});
        rd(1, d);
        pulse(m[2:0]);
        x = |(e[2:0] & m[2:0]);
        chk("R5 irq_n", {7'b0, irq_n}, {7'b0, ~x});
        rd(1, d);
        chk("R3 R4 flags", d, {x, m[2:0], 4'h0});
        peek_flags(d);
        chk("R6 cleared", d, 8'h00);
        chk("R6 irq_n", {7'b0, irq_n}, 8'h01);
      end
    end

    wr(0, 8'h00); rd(1, d);
    pulse(3'b010);
    chk("R3 disabled irq_n", {7'b0, irq_n}, 8'h01);
    wr(0, 8'h20);
    chk("R4 late enable irq_n", {7'b0, irq_n}, 8'h00);
    wr(0, 8'h00);
    chk("R4 sticky irq_n", {7'b0, irq_n}, 8'h00);
    rd(1, d);
    chk("R9 oneshot read", d, 8'hA0);
    chk("R9 oneshot irq_n", {7'b0, irq_n}, 8'h01);

    wr(0, 8'h40); rd(1, d);
    @(negedge clk); reg_sel = 1; rd_en = 1; ev_periodic = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0; ev_periodic = 0;
    chk("R7 old value", d, 8'h00);
    peek_flags(d);
    chk("R7 survived", d, 8'hC0);
    chk("R7 irq_n", {7'b0, irq_n}, 8'h00);
    rd(1, d);

    wr(0, 8'h10); rd(1, d);
    pulse(3'b001);
    rd(0, d);
    chk("R10 ctl", d, 8'h10);
    peek_flags(d);
    chk("R10 flags kept", d, 8'h90);
    rd(1, d);

    wr(0, 8'h00);
    wr(1, 8'hFF);
    peek_flags(d);
    chk("R8 flag write ignored", d, 8'h00);
    rd(0, d);
    chk("R8 ctl untouched", d, 8'h00);
    chk("R8 irq_n", {7'b0, irq_n}, 8'h01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule